// File: doc/BRIEF.md
# Character-Cell Monochrome Text Raster Generator

This block turns a grid of one-byte character codes into a 640x480, roughly 60 Hz raster. One pixel clock of 25 MHz drives everything. The codes and the glyph bitmaps sit in a single 8-bit asynchronous SRAM. Every 8-pixel cell needs exactly two reads from it. The first read fetches the character code at `row_base + column`. The second fetches the glyph byte at `GLYPH_BASE + code * H + line`, where `H` is the programmable cell height (1 to 31 scanlines) and `line` is the scanline inside the current text row.

The glyph byte is serialised most significant bit first, one pixel per clock. A set bit drives all three colour lines high (white) and a clear bit drives them low (black). Fetching runs one cell ahead of the beam. The sync and blanking controls are delayed to match, so at the outputs they stay aligned with the pixels.

Scanlines below the last text row that fits completely in the active height are blanked. The height input is taken once per frame. The SRAM write path and the arbitration for its address bus lie outside this block.

Top module: `vga_text_ctrl`

## Requirements
- R1: A line lasts H_ACTIVE+H_FP+H_SYNC+H_BP clocks (800 by default). The horizontal sync is active low for H_SYNC clocks and falls H_ACTIVE+H_FP clocks after the line's first active pixel.
- R2: A frame lasts V_ACTIVE+V_FP+V_SYNC+V_BP lines (525 by default). The vertical sync is active low for V_SYNC whole lines. The first active line begins V_BP lines after the vertical sync rises.
- R3: For the cell in column c of text row r, the address r*(H_ACTIVE/8)+c is on the SRAM address bus 8 and 7 clocks before that cell's first pixel appears at the colour outputs.
- R4: From 6 clocks to 1 clock before the cell's first pixel, the SRAM address is GLYPH_BASE + code*H + line (16 bits), where code is the byte read by the R3 access.
- R5: Within a visible cell, pixel k (k = 0 is leftmost) shows bit 7-k of the glyph byte. A 1 drives red, green and blue all to 1, and a 0 drives all three to 0.
- R6: Outside the active window (porches and sync periods) all three colour outputs are 0.
- R7: Active scanlines at or below floor(V_ACTIVE/H)*H are black. This covers a partial text row left over when V_ACTIVE is not a multiple of H.
- R8: The character height input is taken only at the frame boundary. A change in the middle of a frame has no effect until the next frame. H must lie in 1..31.
- R9: Reset is synchronous and active low. While it is held, the colour outputs are 0, both syncs are 1 and the SRAM address is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock; all logic runs on it |
| rst_n | input | 1 | Synchronous active-low reset |
| char_h | input | CH_W (5) | Character cell height in scanlines, 1..31 |
| sram_addr | output | ADDR_W (16) | Read address to the shared SRAM |
| sram_rdata | input | 8 | Asynchronous read data from the SRAM |
| vga_hs_n | output | 1 | Horizontal sync, active low |
| vga_vs_n | output | 1 | Vertical sync, active low |
| vga_r | output | 1 | Red pixel |
| vga_g | output | 1 | Green pixel |
| vga_b | output | 1 | Blue pixel |

## Verification
The hardest situation to reach from the ports is a height change that arrives partway through a frame. The changed height has to be held off until the frame boundary. That frame's cells, addresses and blanking must still follow the old height, and the next frame must follow the new one. The stimulus counts clocks from the rising edge of vertical sync and changes the height input on active line 10. It then compares every pixel and every address of that frame against the old height, and the whole next frame against the new height. Uneven heights such as 13 and 14 leave a partial row at the bottom, so the blanking rule is exercised on every frame that uses them.

// File: rtl/vtc_pkg.sv
// Package: shared types and constants for the text raster generator.
// Assumes glyph rows are one byte wide and cells are eight pixels wide.
package vtc_pkg;
    localparam int GLYPH_W = 8;
    localparam int PHASE_W = 3;

    // Control bits that travel alongside the pixel data.
    typedef struct packed {
        logic hs_n;
        logic vs_n;
        logic act;
    } vtc_ctl_t;

    localparam vtc_ctl_t CTL_IDLE = '{hs_n: 1'b1, vs_n: 1'b1, act: 1'b0};
endpackage

// File: rtl/vtc_mul_u.sv
// Unsigned shift-and-add multiplier, purely combinational.
// Assumes the product width is the sum of the operand widths.
module vtc_mul_u #(
    parameter int A_W = 8,
    parameter int B_W = 5,
    localparam int P_W = A_W + B_W
) (
    input  logic [A_W-1:0] a,
    input  logic [B_W-1:0] b,
    output logic [P_W-1:0] p
);
    logic [P_W-1:0] pp [B_W];

    // One shifted partial product per multiplier bit.
    for (genvar gi = 0; gi < B_W; gi++) begin : g_pp
        assign pp[gi] = b[gi] ? (P_W'(a) << gi) : '0;
    end

    // Add the partial products together.
    always_comb begin
        p = '0;
        for (int i = 0; i < B_W; i++) p = p + pp[i];
    end
endmodule

// File: rtl/vtc_raster_timer.sv
// Raster timer: horizontal and vertical counters, the scanline-in-row
// counter, the text row base address, the per-frame height latch and
// the raw sync and blanking controls.
// Assumes H_ACTIVE is a multiple of 8 and that char_h is in 1..31.
module vtc_raster_timer #(
    parameter int H_ACTIVE = 640,
    parameter int H_FP     = 16,
    parameter int H_SYNC   = 96,
    parameter int H_BP     = 48,
    parameter int V_ACTIVE = 480,
    parameter int V_FP     = 10,
    parameter int V_SYNC   = 2,
    parameter int V_BP     = 33,
    parameter int ADDR_W   = 16,
    parameter int CH_W     = 5,
    localparam int H_TOTAL = H_ACTIVE + H_FP + H_SYNC + H_BP,
    localparam int V_TOTAL = V_ACTIVE + V_FP + V_SYNC + V_BP,
    localparam int HC_W    = $clog2(H_TOTAL),
    localparam int VC_W    = $clog2(V_TOTAL)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [CH_W-1:0]   char_h,
    output logic [HC_W-1:0]   hcnt,
    output logic [CH_W-1:0]   line,
    output logic [ADDR_W-1:0] row_base,
    output logic [CH_W-1:0]   yy_q,
    output logic              hs_raw,
    output logic              vs_raw,
    output logic              act_raw,
    output logic              fetch_en
);
    localparam int COLS = H_ACTIVE / 8;
    localparam logic [HC_W-1:0] H_LAST   = HC_W'(H_TOTAL - 1);
    localparam logic [HC_W-1:0] H_ACT_C  = HC_W'(H_ACTIVE);
    localparam logic [HC_W-1:0] HS_BEG   = HC_W'(H_ACTIVE + H_FP);
    localparam logic [HC_W-1:0] HS_END   = HC_W'(H_ACTIVE + H_FP + H_SYNC);
    localparam logic [VC_W-1:0] V_LAST   = VC_W'(V_TOTAL - 1);
    localparam logic [VC_W-1:0] V_ACT_C  = VC_W'(V_ACTIVE);
    localparam logic [VC_W-1:0] VS_BEG   = VC_W'(V_ACTIVE + V_FP);
    localparam logic [VC_W-1:0] VS_END   = VC_W'(V_ACTIVE + V_FP + V_SYNC);

    logic [VC_W-1:0] vcnt;
    logic [VC_W:0]   row_end;
    logic            line_end, frame_end, h_vis, v_vis;

    assign line_end  = (hcnt == H_LAST);
    assign frame_end = line_end && (vcnt == V_LAST);
    assign h_vis     = (hcnt < H_ACT_C);
    assign v_vis     = (vcnt < V_ACT_C);

    // Pixel and line counters.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hcnt <= '0;
            vcnt <= '0;
        end else if (line_end) begin
            hcnt <= '0;
            vcnt <= (vcnt == V_LAST) ? '0 : vcnt + 1'b1;
        end else begin
            hcnt <= hcnt + 1'b1;
        end
    end

    // Scanline within the text row, row base address and height latch.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            line     <= '0;
            row_base <= '0;
            yy_q     <= char_h;
        end else if (frame_end) begin
            line     <= '0;
            row_base <= '0;
            yy_q     <= char_h;
        end else if (line_end && v_vis) begin
            if (line == yy_q - 1'b1) begin
                line     <= '0;
                row_base <= row_base + ADDR_W'(COLS);
            end else begin
                line <= line + 1'b1;
            end
        end
    end

    // Raw controls, decoded from the counters before the output delay.
    assign row_end  = {1'b0, vcnt} - (VC_W+1)'(line) + (VC_W+1)'(yy_q);
    assign fetch_en = h_vis && v_vis;
    assign act_raw  = fetch_en && (row_end <= (VC_W+1)'(V_ACTIVE));
    assign hs_raw   = !((hcnt >= HS_BEG) && (hcnt < HS_END));
    assign vs_raw   = !((vcnt >= VS_BEG) && (vcnt < VS_END));

    // R2: at the end of a frame every frame-scoped counter returns to zero.
    a_r2_frame_wrap: assert property (@(posedge clk) disable iff (!rst_n)
        frame_end |=> (vcnt == '0) && (line == '0) && (row_base == '0));
    // R7: the scanline counter stays below the latched cell height.
    a_r7_line_lt_height: assert property (@(posedge clk) disable iff (!rst_n)
        line < yy_q);
    // R8: the height latch changes only on the cycle that starts a frame.
    a_r8_height_held: assert property (@(posedge clk) disable iff (!rst_n)
        !((hcnt == '0) && (vcnt == '0)) |-> $stable(yy_q));
endmodule

// File: rtl/vtc_cell_fetch.sv
// Cell fetcher: uses two SRAM reads per 8-clock slot, first the
// character code and then that glyph's byte for the current scanline.
// Assumes the SRAM read is asynchronous, with data valid in the cycle
// after the address register loads.
module vtc_cell_fetch
    import vtc_pkg::*;
#(
    parameter int ADDR_W     = 16,
    parameter int GLYPH_BASE = 4096,
    parameter int CH_W       = 5,
    parameter int COL_W      = 7
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               fetch_en,
    input  logic [PHASE_W-1:0] phase,
    input  logic [COL_W-1:0]   col,
    input  logic [ADDR_W-1:0]  row_base,
    input  logic [CH_W-1:0]    line,
    input  logic [CH_W-1:0]    yy_q,
    input  logic [GLYPH_W-1:0] sram_rdata,
    output logic [ADDR_W-1:0]  sram_addr,
    output logic [GLYPH_W-1:0] glyph_q
);
    logic [GLYPH_W-1:0]      code_q;
    logic [GLYPH_W+CH_W-1:0] glyph_off;

    vtc_mul_u #(.A_W(GLYPH_W), .B_W(CH_W)) mul_i (
        .a (code_q),
        .b (yy_q),
        .p (glyph_off)
    );

    // Slot sequence: text address, capture code, glyph address, capture glyph.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sram_addr <= '0;
            code_q    <= '0;
            glyph_q   <= '0;
        end else if (fetch_en) begin
            case (phase)
                3'd0: sram_addr <= row_base + ADDR_W'(col);
                3'd1: code_q    <= sram_rdata;
                3'd2: sram_addr <= ADDR_W'(GLYPH_BASE) + ADDR_W'(glyph_off)
                                   + ADDR_W'(line);
                3'd4: glyph_q   <= sram_rdata;
                default: ;
            endcase
        end
    end

    // R4: during the glyph part of a slot the address is in the glyph region.
    a_r4_glyph_region: assert property (@(posedge clk) disable iff (!rst_n)
        (fetch_en && (phase >= 3'd3)) |-> (sram_addr >= ADDR_W'(GLYPH_BASE)));
endmodule

// File: rtl/vtc_pixel_out.sv
// Pixel output: shifts the glyph byte out MSB first and delays the
// sync and blanking controls by the same number of stages so they
// reach the pins together with the pixels.
// Assumes 'load' pulses on the last clock of each 8-clock slot.
module vtc_pixel_out
    import vtc_pkg::*;
#(
    parameter int LAT = 8
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               load,
    input  logic [GLYPH_W-1:0] glyph,
    input  logic               hs_raw,
    input  logic               vs_raw,
    input  logic               act_raw,
    output logic               vga_hs_n,
    output logic               vga_vs_n,
    output logic               pix
);
    vtc_ctl_t           pipe [LAT];
    logic [GLYPH_W-1:0] shreg;

    // Delay chain for the controls; one register per stage.
    for (genvar gs = 0; gs < LAT; gs++) begin : g_stage
        always_ff @(posedge clk) begin
            if (!rst_n)       pipe[gs] <= CTL_IDLE;
            else if (gs == 0) pipe[gs] <= '{hs_n: hs_raw, vs_n: vs_raw, act: act_raw};
            else              pipe[gs] <= pipe[(gs == 0) ? 0 : gs-1];
        end
    end

    // Pixel shifter: load at the cell boundary, otherwise shift left.
    always_ff @(posedge clk) begin
        if (!rst_n)    shreg <= '0;
        else if (load) shreg <= glyph;
        else           shreg <= {shreg[GLYPH_W-2:0], 1'b0};
    end

    // Output registers: the syncs, and the blanked pixel.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            vga_hs_n <= 1'b1;
            vga_vs_n <= 1'b1;
            pix      <= 1'b0;
        end else begin
            vga_hs_n <= pipe[LAT-1].hs_n;
            vga_vs_n <= pipe[LAT-1].vs_n;
            pix      <= shreg[GLYPH_W-1] && pipe[LAT-1].act;
        end
    end
endmodule

// File: rtl/vga_text_ctrl.sv
// Top level of the text raster generator. Connects the timer, the cell
// fetcher and the pixel output stage.
// Assumes one clock equals one pixel and the SRAM is dedicated to reads
// while this block owns its address bus.
module vga_text_ctrl
    import vtc_pkg::*;
#(
    parameter int H_ACTIVE   = 640,
    parameter int H_FP       = 16,
    parameter int H_SYNC     = 96,
    parameter int H_BP       = 48,
    parameter int V_ACTIVE   = 480,
    parameter int V_FP       = 10,
    parameter int V_SYNC     = 2,
    parameter int V_BP       = 33,
    parameter int ADDR_W     = 16,
    parameter int GLYPH_BASE = 4096,
    parameter int CH_W       = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [CH_W-1:0]   char_h,
    output logic [ADDR_W-1:0] sram_addr,
    input  logic [7:0]        sram_rdata,
    output logic              vga_hs_n,
    output logic              vga_vs_n,
    output logic              vga_r,
    output logic              vga_g,
    output logic              vga_b
);
    localparam int H_TOTAL = H_ACTIVE + H_FP + H_SYNC + H_BP;
    localparam int HC_W    = $clog2(H_TOTAL);
    localparam int COL_W   = HC_W - PHASE_W;
    localparam int LAT     = GLYPH_W;

    logic [HC_W-1:0]    hcnt;
    logic [CH_W-1:0]    line, yy_q;
    logic [ADDR_W-1:0]  row_base;
    logic [GLYPH_W-1:0] glyph_q;
    logic               hs_raw, vs_raw, act_raw, fetch_en, pix;

    vtc_raster_timer #(
        .H_ACTIVE(H_ACTIVE), .H_FP(H_FP), .H_SYNC(H_SYNC), .H_BP(H_BP),
        .V_ACTIVE(V_ACTIVE), .V_FP(V_FP), .V_SYNC(V_SYNC), .V_BP(V_BP),
        .ADDR_W(ADDR_W), .CH_W(CH_W)
    ) timer_i (
        .clk(clk), .rst_n(rst_n), .char_h(char_h), .hcnt(hcnt),
        .line(line), .row_base(row_base), .yy_q(yy_q), .hs_raw(hs_raw),
        .vs_raw(vs_raw), .act_raw(act_raw), .fetch_en(fetch_en)
    );

    vtc_cell_fetch #(
        .ADDR_W(ADDR_W), .GLYPH_BASE(GLYPH_BASE), .CH_W(CH_W), .COL_W(COL_W)
    ) fetch_i (
        .clk(clk), .rst_n(rst_n), .fetch_en(fetch_en),
        .phase(hcnt[PHASE_W-1:0]), .col(hcnt[HC_W-1:PHASE_W]),
        .row_base(row_base), .line(line), .yy_q(yy_q),
        .sram_rdata(sram_rdata), .sram_addr(sram_addr), .glyph_q(glyph_q)
    );

    vtc_pixel_out #(.LAT(LAT)) pixel_i (
        .clk(clk), .rst_n(rst_n), .load(hcnt[PHASE_W-1:0] == 3'd7),
        .glyph(glyph_q), .hs_raw(hs_raw), .vs_raw(vs_raw),
        .act_raw(act_raw), .vga_hs_n(vga_hs_n), .vga_vs_n(vga_vs_n),
        .pix(pix)
    );

    assign vga_r = pix;
    assign vga_g = pix;
    assign vga_b = pix;

    // R6: the colour lines are black while either sync pulse is active.
    a_r6_black_in_sync: assert property (@(posedge clk) disable iff (!rst_n)
        (!vga_hs_n || !vga_vs_n) |-> (!vga_r && !vga_g && !vga_b));
endmodule

// File: tb/vga_text_ctrl_tb_top.sv
// Bench: a reduced raster for short frames; the SRAM is a hash of the address.
module vga_text_ctrl_tb_top;
    localparam int H_ACTIVE = 64, H_FP = 4, H_SYNC = 8, H_BP = 4;
    localparam int V_ACTIVE = 40, V_FP = 2, V_SYNC = 2, V_BP = 2;
    localparam int GBASE    = 1024;
    localparam int H_TOTAL  = H_ACTIVE + H_FP + H_SYNC + H_BP;
    localparam int V_TOTAL  = V_ACTIVE + V_FP + V_SYNC + V_BP;
    localparam int FRAME    = H_TOTAL * V_TOTAL;
    localparam int COLS     = H_ACTIVE / 8;
    localparam int NVEC     = 6;
    // Stimulus table: cell height and the number of complete text rows.
    localparam int VEC_H    [NVEC] = '{14, 16, 1, 31, 13, 8};
    localparam int VEC_ROWS [NVEC] = '{2, 2, 40, 1, 3, 5};

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [4:0]  char_h = 5'd14;
    logic [15:0] sram_addr;
    logic [7:0]  sram_rdata;
    logic        vga_hs_n, vga_vs_n, vga_r, vga_g, vga_b;
    int          n_checks = 0, n_fail = 0;
    bit          done = 1'b0;

    always #4 clk = ~clk;

    function automatic logic [7:0] mem_byte(int a);
        int v;
        v = (a * 157) ^ (a >> 3) ^ 90;
        return v[7:0];
    endfunction

    assign sram_rdata = mem_byte(int'(sram_addr));

    vga_text_ctrl #(
        .H_ACTIVE(H_ACTIVE), .H_FP(H_FP), .H_SYNC(H_SYNC), .H_BP(H_BP),
        .V_ACTIVE(V_ACTIVE), .V_FP(V_FP), .V_SYNC(V_SYNC), .V_BP(V_BP),
        .ADDR_W(16), .GLYPH_BASE(GBASE), .CH_W(5)
    ) dut_i (
        .clk(clk), .rst_n(rst_n), .char_h(char_h), .sram_addr(sram_addr),
        .sram_rdata(sram_rdata), .vga_hs_n(vga_hs_n), .vga_vs_n(vga_vs_n),
        .vga_r(vga_r), .vga_g(vga_g), .vga_b(vga_b)
    );

    task automatic check(bit ok, string req, int act, int exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // Walk one frame from the vertical sync rise and compare every cycle.
    task automatic run_frame(int hh, int rows, int new_h);
        int e1 = 0, e2 = 0, e3 = 0, e4 = 0, e5 = 0, e6 = 0, e7 = 0;
        int a1 = 0, x1 = 0, a3 = 0, x3 = 0, a4 = 0, x4 = 0, a5 = 0, x5 = 0;
        @(posedge vga_vs_n);
        for (int t = 0; t < FRAME; t++) begin
            int hp, ln, y, h9, y9, code, gl, ea;
            bit ehs, evs, ep, inwin;
            @(negedge clk);
            hp = t % H_TOTAL; ln = t / H_TOTAL; y = ln - V_BP;
            ehs = !(hp >= H_ACTIVE + H_FP && hp < H_ACTIVE + H_FP + H_SYNC);
            evs = !(ln >= V_BP + V_ACTIVE + V_FP && ln < V_BP + V_ACTIVE + V_FP + V_SYNC);
            if (vga_hs_n != ehs) begin e1++; a1 = vga_hs_n; x1 = ehs; end  // R1
            if (vga_vs_n != evs) e2++;                                        // R2
            inwin = (y >= 0 && y < V_ACTIVE && hp < H_ACTIVE);
            ep = 1'b0;
            if (inwin && y < rows * hh) begin
                code = mem_byte((y / hh) * COLS + hp / 8);
                gl = mem_byte(GBASE + code * hh + y % hh);
                ep = gl[7 - hp % 8];
                if ({vga_r, vga_g, vga_b} != {3{ep}}) begin               // R5
                    e5++; a5 = {vga_r, vga_g, vga_b}; x5 = {3{ep}};
                end
            end else if (inwin) begin
                if ({vga_r, vga_g, vga_b} != 3'b000) e7++;                // R7
            end else if ({vga_r, vga_g, vga_b} != 3'b000) e6++;           // R6
            // Addresses lead their pixels by up to 9 clocks (R3, R4).
            h9 = (t + 9) % H_TOTAL; y9 = (t + 9) / H_TOTAL - V_BP;
            if (y9 >= 0 && y9 < V_ACTIVE && h9 < H_ACTIVE && h9 % 8 != 0) begin
                ea = (y9 / hh) * COLS + h9 / 8;
                if (h9 % 8 <= 2) begin
                    if (int'(sram_addr) != ea) begin e3++; a3 = sram_addr; x3 = ea; end
                end else begin
                    ea = GBASE + mem_byte(ea) * hh + y9 % hh;
                    if (int'(sram_addr) != ea) begin e4++; a4 = sram_addr; x4 = ea; end
                end
            end
            if (new_h != 0 && y == 10 && hp == 0) char_h = 5'(new_h);     // R8
        end
        check(e1 == 0, "R1 hsync timing", a1, x1);
        check(e2 == 0, "R2 vsync timing mismatches", e2, 0);
        check(e3 == 0, "R3 text address", a3, x3);
        check(e4 == 0, "R4 glyph address", a4, x4);
        check(e5 == 0, "R5 pixel stream", a5, x5);
        check(e6 == 0, "R6 blank outside window, mismatches", e6, 0);
        check(e7 == 0, "R7 partial row blank, mismatches", e7, 0);
    endtask

    initial begin
        repeat (5) @(posedge clk);
        @(negedge clk);
        check({vga_r, vga_g, vga_b} == 3'b000, "R9 reset colour", {vga_r, vga_g, vga_b}, 0);
        check(vga_hs_n && vga_vs_n, "R9 reset syncs", {vga_hs_n, vga_vs_n}, 3);
        check(sram_addr == 16'd0, "R9 reset address", sram_addr, 0);
        rst_n = 1'b1;
        for (int i = 0; i < NVEC; i++) begin
            char_h = 5'(VEC_H[i]);
            run_frame(VEC_H[i], VEC_ROWS[i], 0);
        end
        // R8: a mid-frame height change waits for the next frame.
        char_h = 5'd16;
        run_frame(16, 2, 0);
        run_frame(16, 2, 5);
        run_frame(5, 8, 0);
        // R9: reset in the middle of a frame, then a clean restart.
        repeat (700) @(negedge clk);
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        check({vga_r, vga_g, vga_b} == 3'b000, "R9 mid-frame reset colour", {vga_r, vga_g, vga_b}, 0);
        check(vga_hs_n && vga_vs_n, "R9 mid-frame reset syncs", {vga_hs_n, vga_vs_n}, 3);
        check(sram_addr == 16'd0, "R9 mid-frame reset address", sram_addr, 0);
        rst_n = 1'b1;
        run_frame(5, 8, 0);
        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            check(1'b0, "watchdog expired", 0, 1);
            $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
            $finish;
        end
    end
endmodule